// File: doc/BRIEF.md
# Low-Address Store Protection Checker

This block decides, for one memory access per cycle, whether a store must be refused because it targets the protected low part of storage. Two 512-byte windows are guarded: the first 512 bytes of page 0 and the first 512 bytes of page 1. The block also produces a page-level hint that a translation covering either of those pages must not be cached for later writes. It raises a protection-exception request, whose exception code is zero, whenever it refuses a store.

Protection is switched on by one global control bit. When address translation is off, that bit alone decides. When translation is on, the active address-space mode selects one of three private-space bits. Protection applies only if the selected bit is clear. The access-register mode, which this block does not support, raises an error output in place of a protection result. With the parameter `REG_OUT` at 1 (the default), every output is registered and follows its inputs by one clock. With `REG_OUT` at 0 the outputs are purely combinational.

Top module: `lap_guard`

## Requirements
- R1: With protection active and `acc_i` = 1 (write), `blk_store_o` is 1 exactly when the address lies in 0..511 or in 4096..4607, inclusive. Addresses 512..4095, 4608 and above, and every large address are not blocked.
- R2: When `lp_en_i` is 0, `blk_store_o`, `wr_inval_o`, `prot_req_o` and `mode_err_o` are all 0 for every other input.
- R3: When `lp_en_i` is 1 and `xlate_on_i` is 0 (real-address mode), protection is active whatever `priv_i` and `space_i` hold, and `mode_err_o` stays 0.
- R4: When `lp_en_i` and `xlate_on_i` are both 1, protection is active only if the private-space bit of the selected space is 0. The space encodings are: `space_i` 0 = primary, which uses `priv_i[0]`; 2 = secondary, which uses `priv_i[1]`; 3 = home, which uses `priv_i[2]`.
- R5: While protection is active, `wr_inval_o` is 1 for any access type whenever the page-aligned address (4096-byte pages) is page 0 or page 1. It is 0 for addresses of 8192 and above.
- R6: Reads (`acc_i` = 0), instruction fetches (`acc_i` = 2) and the reserved code 3 never set `blk_store_o` or `prot_req_o`, even inside a window.
- R7: `prot_req_o` equals `blk_store_o`, and `prot_code_o` is all zeros whenever `prot_req_o` is 1.
- R8: When `lp_en_i` = 1, `xlate_on_i` = 1 and `space_i` = 1 (access-register mode), `mode_err_o` is 1 and `blk_store_o`, `wr_inval_o` and `prot_req_o` are 0.
- R9: With `REG_OUT` = 1, the outputs show the decision for the inputs present at the previous rising clock edge. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the access |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| lp_en_i | input | 1 | Global low-address protection enable |
| xlate_on_i | input | 1 | Address translation enabled |
| space_i | input | 2 | Address-space mode: 0 primary, 1 access-register, 2 secondary, 3 home |
| priv_i | input | 3 | Private-space bits: [0] primary, [1] secondary, [2] home |
| blk_store_o | output | 1 | Store must be suppressed |
| wr_inval_o | output | 1 | Translation of this page must not be cached for writes |
| prot_req_o | output | 1 | Protection exception request |
| prot_code_o | output | CODE_W | Exception code attached to the request, always zero |
| mode_err_o | output | 1 | Unsupported address-space mode while translating |

## Verification
The bench probes the window edges at 511/512, 4095/4096 and 4607/4608, together with addresses just above 8192 and a far address. An off-by-one comparator there would block a legal store or let a protected one through. Each of the three translated modes is exercised with its own private bit set and the other two bits set. A mux that picked the wrong register would block or pass in the wrong mode. Reads and fetches inside a window, real-address mode with every private bit set and access-register mode with protection on and off are also covered. These cases catch designs that block non-stores, consult private bits with translation off, or report a protection result alongside the mode error.

// File: rtl/lap_pkg.sv
package lap_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } lap_acc_e;

    typedef enum logic [1:0] {
        SPC_PRIMARY   = 2'd0,
        SPC_ACCREG    = 2'd1,
        SPC_SECONDARY = 2'd2,
        SPC_HOME      = 2'd3
    } lap_space_e;

    typedef struct packed {
        logic blk;
        logic inval;
        logic req;
        logic err;
    } lap_res_t;

endpackage

// File: rtl/lap_window_match.sv
module lap_window_match #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int WIN_BYTES = 512,
    parameter int WIN_PAGES = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              exact_hit_o,
    output logic              page_hit_o
);
    localparam int IDX_W = ADDR_W - PAGE_BITS;

    logic [WIN_PAGES-1:0] page_eq;
    logic                 off_in_win;

    // one comparator per guarded page
    for (genvar w = 0; w < WIN_PAGES; w++) begin : g_page
        assign page_eq[w] = (addr_i[ADDR_W-1:PAGE_BITS] == IDX_W'(w));
    end

    assign off_in_win  = (addr_i[PAGE_BITS-1:0] < PAGE_BITS'(WIN_BYTES));
    assign page_hit_o  = |page_eq;
    assign exact_hit_o = page_hit_o && off_in_win;

endmodule

// File: rtl/lap_space_gate.sv
module lap_space_gate
    import lap_pkg::*;
(
    input  logic       lp_en_i,
    input  logic       xlate_on_i,
    input  lap_space_e space_i,
    input  logic [2:0] priv_i,
    output logic       active_o,
    output logic       mode_err_o
);
    logic sel_priv;
    logic sel_bad;

    always_comb begin
        sel_priv = 1'b0;
        sel_bad  = 1'b0;
        unique case (space_i)
            SPC_PRIMARY:   sel_priv = priv_i[0];
            SPC_SECONDARY: sel_priv = priv_i[1];
            SPC_HOME:      sel_priv = priv_i[2];
            default:       sel_bad  = 1'b1;
        endcase
    end

    always_comb begin
        active_o   = 1'b0;
        mode_err_o = 1'b0;
        if (lp_en_i) begin
            if (!xlate_on_i) begin
                active_o = 1'b1;
            end else if (sel_bad) begin
                mode_err_o = 1'b1;
            end else begin
                active_o = !sel_priv;
            end
        end
    end

endmodule

// File: rtl/lap_decide.sv
module lap_decide
    import lap_pkg::*;
(
    input  lap_acc_e acc_i,
    input  logic     active_i,
    input  logic     mode_err_i,
    input  logic     exact_hit_i,
    input  logic     page_hit_i,
    output lap_res_t res_o
);
    logic is_store;

    assign is_store = (acc_i == ACC_WRITE);

    always_comb begin
        res_o.err   = mode_err_i;
        res_o.inval = active_i && page_hit_i;
        res_o.blk   = active_i && exact_hit_i && is_store;
        res_o.req   = res_o.blk;
    end

endmodule

// File: rtl/lap_guard.sv
module lap_guard
    import lap_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int WIN_BYTES = 512,
    parameter int WIN_PAGES = 2,
    parameter int CODE_W    = 64,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        acc_i,
    input  logic              lp_en_i,
    input  logic              xlate_on_i,
    input  logic [1:0]        space_i,
    input  logic [2:0]        priv_i,
    output logic              blk_store_o,
    output logic              wr_inval_o,
    output logic              prot_req_o,
    output logic [CODE_W-1:0] prot_code_o,
    output logic              mode_err_o
);
    logic     exact_hit;
    logic     page_hit;
    logic     active;
    logic     mode_err;
    lap_res_t res_c;
    lap_res_t res_q;

    lap_window_match #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .WIN_BYTES (WIN_BYTES),
        .WIN_PAGES (WIN_PAGES)
    ) win_i (
        .addr_i      (addr_i),
        .exact_hit_o (exact_hit),
        .page_hit_o  (page_hit)
    );

    lap_space_gate gate_i (
        .lp_en_i    (lp_en_i),
        .xlate_on_i (xlate_on_i),
        .space_i    (lap_space_e'(space_i)),
        .priv_i     (priv_i),
        .active_o   (active),
        .mode_err_o (mode_err)
    );

    lap_decide dec_i (
        .acc_i       (lap_acc_e'(acc_i)),
        .active_i    (active),
        .mode_err_i  (mode_err),
        .exact_hit_i (exact_hit),
        .page_hit_i  (page_hit),
        .res_o       (res_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_q <= '0;
            end else begin
                res_q <= res_c;
            end
        end
    end else begin : g_comb
        assign res_q = res_c;
    end

    assign blk_store_o = res_q.blk;
    assign wr_inval_o  = res_q.inval;
    assign prot_req_o  = res_q.req;
    assign mode_err_o  = res_q.err;
    assign prot_code_o = '0;

endmodule

// File: rtl/lap_guard_chk.sv
module lap_guard_chk
    import lap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CODE_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic [1:0]        acc_i,
    input logic              lp_en_i,
    input logic              xlate_on_i,
    input logic [1:0]        space_i,
    input lap_res_t          res_c,
    input logic              blk_store_o,
    input logic              wr_inval_o,
    input logic              prot_req_o,
    input logic [CODE_W-1:0] prot_code_o,
    input logic              mode_err_o
);
    assert_low_page_blocked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_en_i && !xlate_on_i && acc_i == 2'd1 && addr_i == '0) |-> res_c.blk);

    assert_off_means_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lp_en_i |-> (res_c == '0));

    assert_real_mode_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xlate_on_i |-> !res_c.err);

    assert_block_inside_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_store_o |-> wr_inval_o);

    assert_nonstore_never_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i != 2'd1) |-> (!res_c.blk && !res_c.req));

    assert_req_zero_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_req_o |-> (prot_code_o == '0 && blk_store_o));

    assert_err_excludes_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_err_o |-> (!blk_store_o && !wr_inval_o && !prot_req_o));

    assert_accreg_flags_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_en_i && xlate_on_i && space_i == 2'd1) |-> res_c.err);

endmodule

bind lap_guard lap_guard_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .acc_i       (acc_i),
    .lp_en_i     (lp_en_i),
    .xlate_on_i  (xlate_on_i),
    .space_i     (space_i),
    .res_c       (res_c),
    .blk_store_o (blk_store_o),
    .wr_inval_o  (wr_inval_o),
    .prot_req_o  (prot_req_o),
    .prot_code_o (prot_code_o),
    .mode_err_o  (mode_err_o)
);

// File: tb/lap_guard_tb_top.sv
module lap_guard_tb_top;

    localparam int ADDR_W = 64;
    localparam int CODE_W = 64;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [1:0]        acc_i = 2'd1;
    logic              lp_en_i = 1'b1;
    logic              xlate_on_i = 1'b0;
    logic [1:0]        space_i = 2'd0;
    logic [2:0]        priv_i = 3'd0;
    logic              blk_store_o;
    logic              wr_inval_o;
    logic              prot_req_o;
    logic [CODE_W-1:0] prot_code_o;
    logic              mode_err_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk_i = ~clk_i;

    lap_guard #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) dut_i (.*);

    // expected {blk, inval, req, err}, from the requirements
    function automatic logic [3:0] expect_of(logic [63:0] a, logic [1:0] acc,
                                              logic lp, logic xl,
                                              logic [1:0] sp, logic [2:0] pv);
        logic act, err, exact, page, blk, inval;
        act = 1'b0;
        err = 1'b0;
        if (lp) begin
            if (!xl) act = 1'b1;
            else if (sp == 2'd0) act = !pv[0];
            else if (sp == 2'd2) act = !pv[1];
            else if (sp == 2'd3) act = !pv[2];
            else err = 1'b1;
        end
        exact = (a <= 64'd511) || (a >= 64'd4096 && a <= 64'd4607);
        page  = (a < 64'd8192);
        blk   = act && exact && (acc == 2'd1);
        inval = act && page;
        return {blk, inval, blk, err};
    endfunction

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_check(string req, logic [63:0] a, logic [1:0] acc,
                               logic lp, logic xl, logic [1:0] sp, logic [2:0] pv);
        logic [3:0] e;
        addr_i = a; acc_i = acc; lp_en_i = lp; xlate_on_i = xl;
        space_i = sp; priv_i = pv;
        e = expect_of(a, acc, lp, xl, sp, pv);
        @(negedge clk_i);   // one posedge in between: R9 latency
        cmp(req, "blk_store", 64'(blk_store_o), 64'(e[3]));
        cmp(req, "wr_inval",  64'(wr_inval_o),  64'(e[2]));
        cmp(req, "prot_req",  64'(prot_req_o),  64'(e[1]));
        cmp(req, "mode_err",  64'(mode_err_o),  64'(e[0]));
        cmp(req, "prot_code", prot_code_o, 64'd0);
    endtask

    task automatic t_reset_r9();
        @(negedge clk_i);
        cmp("R9", "reset blk", 64'(blk_store_o), 64'd0);
        cmp("R9", "reset inval", 64'(wr_inval_o), 64'd0);
        cmp("R9", "reset req", 64'(prot_req_o), 64'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        cmp("R9", "first edge blk", 64'(blk_store_o), 64'd1);
    endtask

    task automatic t_latency_r9();
        addr_i = 64'd100; acc_i = 2'd1; lp_en_i = 1'b1; xlate_on_i = 1'b0;
        @(negedge clk_i);
        addr_i = 64'd9000;
        #1;
        cmp("R9", "holds until edge", 64'(blk_store_o), 64'd1);
        @(negedge clk_i);
        cmp("R9", "follows after edge", 64'(blk_store_o), 64'd0);
    endtask

    task automatic t_edges_r1();
        logic [63:0] pts [10] = '{64'd0, 64'd511, 64'd512, 64'd4095, 64'd4096,
                                  64'd4607, 64'd4608, 64'd8191, 64'd8192,
                                  64'h0000_0001_0000_0100};
        foreach (pts[i]) apply_check("R1", pts[i], 2'd1, 1'b1, 1'b0, 2'd0, 3'd0);
        apply_check("R1", 64'd4200, 2'd1, 1'b1, 1'b1, 2'd3, 3'd3);
    endtask

    task automatic t_disabled_r2();
        apply_check("R2", 64'd0, 2'd1, 1'b0, 1'b0, 2'd0, 3'd0);
        apply_check("R2", 64'd4100, 2'd1, 1'b0, 1'b1, 2'd1, 3'd7);
    endtask

    task automatic t_real_r3();
        apply_check("R3", 64'd8, 2'd1, 1'b1, 1'b0, 2'd1, 3'd7);
        apply_check("R3", 64'd4500, 2'd1, 1'b1, 1'b0, 2'd2, 3'd7);
    endtask

    task automatic t_space_sel_r4();
        for (int s = 0; s < 4; s++) begin
            if (s == 1) continue;
            for (int p = 0; p < 8; p++)
                apply_check("R4", 64'd16, 2'd1, 1'b1, 1'b1, 2'(s), 3'(p));
        end
    endtask

    task automatic t_inval_r5();
        apply_check("R5", 64'd3000, 2'd0, 1'b1, 1'b0, 2'd0, 3'd0);
        apply_check("R5", 64'd8000, 2'd2, 1'b1, 1'b1, 2'd0, 3'd6);
        apply_check("R5", 64'd8192, 2'd1, 1'b1, 1'b0, 2'd0, 3'd0);
    endtask

    task automatic t_nonstore_r6();
        for (int t = 0; t < 4; t++) begin
            if (t == 1) continue;
            apply_check("R6", 64'd4, 2'(t), 1'b1, 1'b0, 2'd0, 3'd0);
            apply_check("R6", 64'd4097, 2'(t), 1'b1, 1'b1, 2'd2, 3'd0);
        end
    endtask

    task automatic t_req_code_r7();
        apply_check("R7", 64'd256, 2'd1, 1'b1, 1'b1, 2'd0, 3'd6);
        apply_check("R7", 64'd4352, 2'd1, 1'b1, 1'b1, 2'd2, 3'd5);
    endtask

    task automatic t_accreg_r8();
        apply_check("R8", 64'd0, 2'd1, 1'b1, 1'b1, 2'd1, 3'd0);
        apply_check("R8", 64'd20000, 2'd0, 1'b1, 1'b1, 2'd1, 3'd0);
        apply_check("R8", 64'd0, 2'd1, 1'b0, 1'b1, 2'd1, 3'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        t_reset_r9();
        t_latency_r9();
        t_edges_r1();
        t_disabled_r2();
        t_real_r3();
        t_space_sel_r4();
        t_inval_r5();
        t_nonstore_r6();
        t_req_code_r7();
        t_accreg_r8();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule